// File: doc/BRIEF.md
# Serial ADC Device-Side Port Model

This block models the digital side of a self-calibrating 16-bit serial converter, so that it can stand in as a device under test for a host controller. A parallel input word takes the place of the analog path. The host opens a conversion with a falling edge on the sample control. It then supplies 17 pulses on the conversion clock. The block answers with a busy flag, a serial data line and a derived data clock, and sends the word in twos complement, most significant bit first.

An asynchronous calibration request acts as a hard reset. While the request is high, the block is held in reset with busy high. When the request falls, the block runs a calibration of fixed length, counted in conversion-clock pulses. During calibration the sample control has a second meaning: high keeps the data line low, and low lets a fixed diagnostic pattern appear on it. A validity flag stays low until a calibration has finished and one warm-up conversion has followed it.

All logic runs on a fast system clock. The conversion clock and the sample control are treated as level inputs, and the block acts on the edges it detects in them.

Top module: `adc_serial_port`

## Requirements
- R1: In idle, the system-clock cycle in which `sampleCtl` is seen to fall captures `convWord`. Later changes of `convWord` have no effect on the word sent.
- R2: `busy` rises in the cycle after the first rising `convClk` edge that follows the capture. It falls in the cycle after the 17th rising edge. `busy` stays low between the capture and that first edge.
- R3: `serOut` changes only on a valid rising `convClk` edge. The first edge leaves it unchanged. Edges 2 to 17 put bits 15 down to 0 of the captured word on it, MSB first.
- R4: `serClk` goes high in the cycle after a valid rising `convClk` edge, and low in the cycle after any falling `convClk` edge. A valid edge is any edge that arrives while armed, converting or calibrating.
- R5: While idle, `convClk` pulses leave `serOut` unchanged and produce no `serClk` pulse.
- R6: Changes of `sampleCtl` are ignored from the capture until `busy` falls. If `sampleCtl` is high when `busy` falls, its next falling edge starts a new conversion.
- R7: While `calReq` is high, `busy` is forced high and `serOut` and `serClk` are forced low, without waiting for a clock. Any conversion or calibration in progress is abandoned.
- R8: After `calReq` falls, `busy` stays high for exactly `CAL_EDGES` rising `convClk` edges. It falls in the cycle after the last of them.
- R9: Every calibration edge pulses `serClk` and advances a 16-bit diagnostic register. The register is set to 0xACE1 by the calibration request. It shifts left, and the XOR of bits 15, 13, 12 and 10 enters bit 0. On each edge `serOut` takes 0 if `sampleCtl` is high, and that XOR bit if `sampleCtl` is low.
- R10: `resultValid` is low after reset and after a calibration request. When a conversion finishes, it is set high only if the conversion ended after a completed calibration and after at least one earlier conversion that also followed that calibration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for all logic |
| rstN | input | 1 | Asynchronous active-low power-up reset; leaves the block idle and uncalibrated |
| calReq | input | 1 | Asynchronous calibration request and hard reset, active high |
| sampleCtl | input | 1 | Sample control: its falling edge captures; during calibration it selects the data line mode |
| convClk | input | 1 | Conversion clock from the host |
| convWord | input | 16 | Stand-in for the converted analog value |
| busy | output | 1 | High during a conversion or calibration |
| serOut | output | 1 | Serial data, twos complement, MSB first |
| serClk | output | 1 | Data clock derived from valid conversion clock edges |
| resultValid | output | 1 | The most recently completed word can be trusted |

## Verification
The bench changes the input word right after the capture and toggles the sample control during a conversion. A design that still listened to either input would send a corrupted word or start a second conversion early. It also pulses the conversion clock in idle and starts a new conversion with the sample control already high when busy falls. These catch a port that keeps shifting after the 17th edge, and one that misses an acquisition opened while busy. It aborts a conversion part-way with a calibration request and counts calibration edges one by one. An off-by-one in the calibration length, or a reset that is not instant, shows up as a busy level in the wrong cycle. The validity flag is followed through uncalibrated, warm-up and settled conversions, so that a design that skips the warm-up conversion is caught.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_CONV  = 2'd2,
    PH_CALIB = 2'd3
  } phase_t;

  // strobes from control to datapath, one system-clock cycle wide
  typedef struct packed {
    logic loadWord;   // capture the parallel word
    logic shiftBit;   // put the next data bit on the line
    logic calBit;     // calibration edge: advance diagnostic register
    logic forceLow;   // calibration edge drives zero instead of pattern
    logic pulseRise;  // valid conversion clock rise
    logic pulseFall;  // any conversion clock fall
  } strobe_t;

  localparam int DIAG_W = 16;
  localparam logic [DIAG_W-1:0] DIAG_TAPS = 16'hB400;  // bits 15,13,12,10

endpackage

// File: rtl/adc_port_ctrl.sv
module adc_port_ctrl
  import adc_port_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CAL_EDGES = 4800
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    calReq,
  input  logic    sampleCtl,
  input  logic    convClk,
  output strobe_t strobe,
  output logic    busy,
  output logic    resultValid
);
  localparam int CONV_EDGES = WORD_W + 1;
  localparam int MAX_EDGES  = (CAL_EDGES > CONV_EDGES) ? CAL_EDGES : CONV_EDGES;
  localparam int CNT_W      = $clog2(MAX_EDGES + 1);
  localparam logic [CNT_W-1:0] LAST_CONV = CNT_W'(CONV_EDGES - 1);
  localparam logic [CNT_W-1:0] LAST_CAL  = CNT_W'(CAL_EDGES - 1);

  phase_t           phase;
  logic [CNT_W-1:0] edgeCnt;
  logic             clkPrev, sampPrev;
  logic             calibrated, primed;
  logic             clkRise, clkFall, sampFall;

  assign clkRise  = convClk & ~clkPrev;
  assign clkFall  = ~convClk & clkPrev;
  assign sampFall = sampPrev & ~sampleCtl;

  always_comb begin
    strobe.loadWord  = (phase == PH_IDLE) && sampFall;
    strobe.shiftBit  = (phase == PH_CONV) && clkRise;
    strobe.calBit    = (phase == PH_CALIB) && clkRise;
    strobe.forceLow  = sampleCtl;
    strobe.pulseRise = (phase != PH_IDLE) && clkRise;
    strobe.pulseFall = clkFall;
  end

  assign busy = (phase == PH_CONV) || (phase == PH_CALIB);

  always_ff @(posedge clk or negedge rstN or posedge calReq) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      edgeCnt     <= '0;
      clkPrev     <= 1'b0;
      sampPrev    <= 1'b0;
      calibrated  <= 1'b0;
      primed      <= 1'b0;
      resultValid <= 1'b0;
    end else if (calReq) begin
      phase       <= PH_CALIB;
      edgeCnt     <= '0;
      clkPrev     <= 1'b0;
      sampPrev    <= 1'b0;
      calibrated  <= 1'b0;
      primed      <= 1'b0;
      resultValid <= 1'b0;
    end else begin
      clkPrev  <= convClk;
      sampPrev <= sampleCtl;
      unique case (phase)
        PH_IDLE:  if (sampFall) phase <= PH_ARMED;
        PH_ARMED: if (clkRise) begin
          phase   <= PH_CONV;
          edgeCnt <= CNT_W'(1);
        end
        PH_CONV: if (clkRise) begin
          if (edgeCnt == LAST_CONV) begin
            phase       <= PH_IDLE;
            edgeCnt     <= '0;
            resultValid <= calibrated & primed;
            primed      <= calibrated;
          end else begin
            edgeCnt <= edgeCnt + 1'b1;
          end
        end
        PH_CALIB: if (clkRise) begin
          if (edgeCnt == LAST_CAL) begin
            phase       <= PH_IDLE;
            edgeCnt     <= '0;
            calibrated  <= 1'b1;
            primed      <= 1'b0;
            resultValid <= 1'b0;
          end else begin
            edgeCnt <= edgeCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_port_dp.sv
module adc_port_dp
  import adc_port_pkg::*;
#(
  parameter int              WORD_W    = 16,
  parameter logic [DIAG_W-1:0] DIAG_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calReq,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] convWord,
  output logic              serOut,
  output logic              serClk
);
  logic [WORD_W-1:0] shiftReg;
  logic [DIAG_W-1:0] diag;
  logic              diagFb;

  assign diagFb = ^(diag & DIAG_TAPS);

  always_ff @(posedge clk or negedge rstN or posedge calReq) begin
    if (!rstN || calReq) begin
      shiftReg <= '0;
      diag     <= DIAG_SEED;
      serOut   <= 1'b0;
      serClk   <= 1'b0;
    end else begin
      if (strobe.loadWord) begin
        shiftReg <= convWord;
      end else if (strobe.shiftBit) begin
        serOut   <= shiftReg[WORD_W-1];
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};
      end
      if (strobe.calBit) begin
        diag   <= {diag[DIAG_W-2:0], diagFb};
        serOut <= strobe.forceLow ? 1'b0 : diagFb;
      end
      if (strobe.pulseRise)      serClk <= 1'b1;
      else if (strobe.pulseFall) serClk <= 1'b0;
    end
  end

endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_port_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int CAL_EDGES = 4800
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              calReq,
  input  logic              sampleCtl,
  input  logic              convClk,
  input  logic [WORD_W-1:0] convWord,
  output logic              busy,
  output logic              serOut,
  output logic              serClk,
  output logic              resultValid
);
  strobe_t strobe;

  adc_port_ctrl #(.WORD_W(WORD_W), .CAL_EDGES(CAL_EDGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .calReq(calReq), .sampleCtl(sampleCtl),
    .convClk(convClk), .strobe(strobe), .busy(busy), .resultValid(resultValid)
  );

  adc_port_dp #(.WORD_W(WORD_W)) dp_i (
    .clk(clk), .rstN(rstN), .calReq(calReq), .strobe(strobe),
    .convWord(convWord), .serOut(serOut), .serClk(serClk)
  );

endmodule

// File: rtl/adc_port_chk.sv
module adc_port_chk (
  input logic clk,
  input logic rstN,
  input logic calReq,
  input logic busy,
  input logic serOut,
  input logic serClk,
  input logic resultValid
);
  // R2
  busy_rise_with_edge_chk: assert property (@(posedge clk) disable iff (!rstN || calReq)
    $rose(busy) |-> $rose(serClk));

  // R3
  data_moves_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN || calReq)
    !$stable(serOut) |-> $rose(serClk));

  // R5
  no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rstN || calReq)
    $rose(serClk) |-> (busy || $past(busy)));

  // R7
  cal_forces_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    calReq |-> (busy && !serOut && !serClk));

  // R10
  valid_at_finish_chk: assert property (@(posedge clk) disable iff (!rstN || calReq)
    $rose(resultValid) |-> $fell(busy));
endmodule

bind adc_serial_port adc_port_chk chk_i (
  .clk(clk), .rstN(rstN), .calReq(calReq), .busy(busy),
  .serOut(serOut), .serClk(serClk), .resultValid(resultValid)
);

// File: tb/adc_serial_port_tb.sv
`timescale 1ns/1ps
module adc_serial_port_tb_top;
  localparam int CAL_N = 40;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic calReq = 1'b0;
  logic sampleCtl = 1'b0;
  logic convClk = 1'b0;
  logic [15:0] convWord = 16'h0;
  logic busy, serOut, serClk, resultValid;

  always #2 clk = ~clk;  // 250 MHz

  adc_serial_port #(.WORD_W(16), .CAL_EDGES(CAL_N)) dut_i (
    .clk(clk), .rstN(rstN), .calReq(calReq), .sampleCtl(sampleCtl),
    .convClk(convClk), .convWord(convWord), .busy(busy), .serOut(serOut),
    .serClk(serClk), .resultValid(resultValid)
  );

  int checks = 0;
  int bad = 0;
  bit done = 0;

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference model: 0 idle, 1 armed, 2 converting, 3 calibrating
  int mPhase, mEdges;
  bit mBusy, mDout, mDclk, mValid, mCalib, mPrimed, mPC, mPS;
  bit [15:0] mDiag;
  bit mBits[$];

  task automatic modelReset(bit toCal);
    mPhase = toCal ? 3 : 0; mEdges = 0; mBusy = toCal; mDout = 0; mDclk = 0;
    mValid = 0; mCalib = 0; mPrimed = 0; mPC = 0; mPS = 0; mDiag = 16'hACE1;
    mBits.delete();
  endtask

  task automatic modelStep();
    bit rise, fall, fb;
    rise = convClk && !mPC;
    fall = !convClk && mPC;
    case (mPhase)
      0: if (mPS && !sampleCtl) begin
           mBits.delete();
           for (int b = 15; b >= 0; b--) mBits.push_back(convWord[b]);
           mPhase = 1;
         end
      1: if (rise) begin mPhase = 2; mEdges = 1; mBusy = 1; mDclk = 1; end
      2: if (rise) begin
           mDclk = 1; mDout = mBits.pop_front(); mEdges++;
           if (mEdges == 17) begin
             mPhase = 0; mBusy = 0; mValid = mCalib && mPrimed; mPrimed = mCalib;
           end
         end
      default: if (rise) begin
           mDclk = 1;
           fb = mDiag[15] ^ mDiag[13] ^ mDiag[12] ^ mDiag[10];
           mDiag = {mDiag[14:0], fb};
           mDout = sampleCtl ? 1'b0 : fb;
           mEdges++;
           if (mEdges == CAL_N) begin
             mPhase = 0; mEdges = 0; mBusy = 0; mCalib = 1; mPrimed = 0; mValid = 0;
           end
         end
    endcase
    if (fall) mDclk = 0;
    mPC = convClk;
    mPS = sampleCtl;
  endtask

  bit capQ[$];
  bit clkSeen = 0;

  always @(negedge clk) begin
    if (!rstN) modelReset(0);
    else if (calReq) modelReset(1);
    check("R2", "busy", busy, mBusy);
    check(mPhase == 3 ? "R9" : "R3", "serOut", serOut, mDout);
    check("R4", "serClk", serClk, mDclk);
    check("R10", "resultValid", resultValid, mValid);
    if (serClk && !clkSeen) capQ.push_back(serOut);
    clkSeen = serClk;
    if (rstN && !calReq) modelStep();
  end

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse();
    convClk = 1; waitCyc(2);
    convClk = 0; waitCyc(2);
  endtask

  // mode 0 plain, 1 toggle sample while busy, 2 leave sample high at the end
  task automatic convert(logic [15:0] word, int mode);
    logic [15:0] got;
    sampleCtl = 1; convWord = word; waitCyc(3);
    sampleCtl = 0; waitCyc(2);
    convWord = ~word;
    check("R2", "busy before first edge", busy, 0);
    capQ.delete();
    for (int i = 1; i <= 17; i++) begin
      if (mode == 1) sampleCtl = (i < 17) ? i[0] : 1'b0;
      if (mode == 2 && i == 17) sampleCtl = 1;
      convClk = 1; waitCyc(2);
      check("R2", "busy after edge", busy, (i < 17) ? 1 : 0);
      convClk = 0; waitCyc(2);
    end
    @(negedge clk);
    check("R3", "serial pulse count", capQ.size(), 17);
    got = '0;
    for (int k = 1; k < 17 && k < capQ.size(); k++) got = {got[14:0], capQ[k]};
    check(mode == 1 ? "R6" : "R1", "received word", got, word);
    waitCyc(1);
  endtask

  task automatic runCal();
    calReq = 1; #1;
    check("R7", "busy on request", busy, 1);
    check("R7", "serOut on request", serOut, 0);
    check("R7", "serClk on request", serClk, 0);
    waitCyc(5);
    calReq = 0; waitCyc(1);
    capQ.delete();
    for (int i = 0; i < CAL_N; i++) begin
      sampleCtl = (i < CAL_N / 2);
      if (i == CAL_N - 1) check("R8", "busy before last edge", busy, 1);
      pulse();
    end
    sampleCtl = 0;
    @(negedge clk);
    check("R8", "busy after last edge", busy, 0);
    check("R9", "calibration pulses", capQ.size(), CAL_N);
    for (int i = 0; i < CAL_N / 2 && i < capQ.size(); i++)
      check("R9", "forced low bit", capQ[i], 0);
    waitCyc(1);
  endtask

  initial begin
    bit keep;
    waitCyc(3);
    rstN = 1; waitCyc(1);
    check("R10", "valid after reset", resultValid, 0);
    check("R2", "busy after reset", busy, 0);

    convert(16'h8001, 0);
    check("R10", "uncalibrated result", resultValid, 0);
    runCal();
    check("R10", "valid after calibration", resultValid, 0);
    convert(16'h7FFF, 0);
    check("R10", "warm-up result", resultValid, 0);
    convert(16'h1234, 1);
    check("R10", "settled result", resultValid, 1);

    keep = serOut; capQ.delete();
    for (int i = 0; i < 5; i++) pulse();
    @(negedge clk);
    check("R5", "idle serOut", serOut, keep);
    check("R5", "idle pulses", capQ.size(), 0);
    waitCyc(1);

    convert(16'hA5C3, 2);
    convert(16'h0000, 0);
    check("R6", "reacquire with sample high", resultValid, 1);

    // abort a conversion with a calibration request
    sampleCtl = 1; convWord = 16'hBEEF; waitCyc(3);
    sampleCtl = 0; waitCyc(2);
    for (int i = 0; i < 5; i++) pulse();
    runCal();
    check("R7", "valid after abort", resultValid, 0);
    convert(16'hFFFF, 0);
    check("R10", "warm-up after abort", resultValid, 0);
    convert(16'h4C1D, 0);
    check("R10", "settled after abort", resultValid, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; bad++;
      $display("FAIL watchdog: run did not finish");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule